// File: doc/BRIEF.md
# Boundary-Scan Test Port with User Chain Routing

This block is the serial test port of a chip. It runs the standard sixteen-state test-port state machine on the test clock, keeps a three-bit instruction register, and chooses which data register sits between the serial input and the serial output. Two data registers are inside the block: a one-bit bypass stage and a boundary register. The boundary register has one cell per I/O and one control cell, and each cell has capture, shift and update stages. The other data paths belong to other blocks. Two user instructions pass the data path to user logic through a select line, a gated data clock and a return-data input. Two more instructions send the serial output from an external readback stream and from the configuration data output.

The boundary register captures the pin values. Under the external-test instruction, its update stage drives the pads and their output enable. Under every other instruction, the core logic keeps the pads. The serial output is launched on the falling test-clock edge. Its enable is high only while an instruction or a data register is shifting.

Top module: `scan_port_ctrl`

## Requirements
- R1: The controller follows the standard 16-state test-port state graph on rising `tck`. Five rising edges in a row with `tms` high reach Test-Logic-Reset from any state. A low `rst_n` at a rising edge also forces that state.
- R2: On entry to Capture-IR the instruction shift stage loads 001. Shift-IR moves bits from `tdi` toward `tdo`, least significant bit first. The instruction is updated on the falling `tck` edge in Update-IR. In Test-Logic-Reset, and under reset, the instruction becomes 111 (bypass).
- R3: The instruction codes are: 000 external test, 001 sample/preload, 010 user chain 1, 011 user chain 2, 100 readback, 101 configure, 110 reserved, 111 bypass. In Shift-DR the output source is chosen by the code. Codes 000 and 001 use the boundary register, 010 uses `user_tdo1`, 011 uses `user_tdo2`, 100 uses `rdbk_data`, 101 uses `cfg_dout`, and 111 uses the bypass stage.
- R4: The bypass stage is one bit. It captures 0 in Capture-DR, so a scan through it returns 0 first and then `tdi` delayed by one shift.
- R5: The boundary register has `N_IO` pin cells and one control cell at the `tdi` end. Cell 0 is at the `tdo` end. On capture, pin cell i takes `pin_in[i]` and the control cell takes 0. The update stage is loaded on the falling edge in Update-DR, but only under codes 000 and 001.
- R6: Under code 000, `pad_out` and `pad_oe` come from the boundary update stage, with `pad_oe` taken from the control cell. Under every other code they follow `core_out` and `core_oe`.
- R7: `sel1` is high exactly while the instruction is 010, and `sel2` exactly while it is 011. The two are never high together.
- R8: `drck` pulses with `tck` only on rising edges taken in Capture-DR or Shift-DR while a user instruction is active. A user scan of L shifts gives L+1 pulses. Other instructions give none.
- R9: `idle` is high exactly while the controller is in Run-Test/Idle.
- R10: `tdo` and `tdo_en` change on the falling `tck` edge. `tdo_en` is high in Shift-IR, and in Shift-DR unless the instruction is the reserved code. In every other state it is low. `tdo` is 0 whenever `tdo_en` is low.
- R11: While the reserved code 110 is the instruction, a data scan never raises `tdo_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on falling tck |
| tdo_en | output | 1 | Output enable for tdo (low means high impedance) |
| sel1 | output | 1 | User chain 1 selected |
| sel2 | output | 1 | User chain 2 selected |
| drck | output | 1 | Gated data clock for user chains |
| idle | output | 1 | Controller is in Run-Test/Idle |
| user_tdo1 | input | 1 | Return data from user chain 1 |
| user_tdo2 | input | 1 | Return data from user chain 2 |
| rdbk_data | input | 1 | Readback stream passed to tdo |
| cfg_dout | input | 1 | Configuration data output passed to tdo |
| pin_in | input | N_IO | Pin values captured by the boundary register |
| core_out | input | N_IO | Pad data from core logic |
| core_oe | input | 1 | Pad output enable from core logic |
| pad_out | output | N_IO | Data driven to the pads |
| pad_oe | output | 1 | Output enable driven to the pads |

## Verification
Some properties are checked on every edge. These cover the exclusive select lines, `tdo_en` appearing only in shift states and never under the reserved code, and `drck` pulsing only while a user chain is selected. They also cover the boundary update stage holding outside Update-DR, the instruction being bypass whenever the controller sits in Test-Logic-Reset, and five high `tms` edges always ending in that state. The bench scenarios show what needs a full scan sequence. This includes the 001 capture pattern, the bit order of the boundary cells, and the routing of each external stream to `tdo`. It also includes preload followed by external test driving the pads, the exact `drck` pulse count, and the reset back to bypass from a user instruction in the middle of a scan.

// File: rtl/scan_pkg.sv
// Package: shared types and constants of the boundary-scan test port.
// Assumes a 3-bit instruction register; the codes are fixed by the spec.
package scan_pkg;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] IR_CAPT = 3'b001;

    // Test-port controller states
    typedef enum logic [3:0] {
        TLR    = 4'd0,
        RTI    = 4'd1,
        SEL_DR = 4'd2,
        CAP_DR = 4'd3,
        SHF_DR = 4'd4,
        EX1_DR = 4'd5,
        PAU_DR = 4'd6,
        EX2_DR = 4'd7,
        UPD_DR = 4'd8,
        SEL_IR = 4'd9,
        CAP_IR = 4'd10,
        SHF_IR = 4'd11,
        EX1_IR = 4'd12,
        PAU_IR = 4'd13,
        EX2_IR = 4'd14,
        UPD_IR = 4'd15
    } tap_state_e;

    // Instruction codes
    typedef enum logic [IR_W-1:0] {
        I_EXTEST = 3'b000,
        I_SAMPLE = 3'b001,
        I_USER1  = 3'b010,
        I_USER2  = 3'b011,
        I_RDBK   = 3'b100,
        I_CFG    = 3'b101,
        I_RSVD   = 3'b110,
        I_BYPASS = 3'b111
    } instr_e;

endpackage

// File: rtl/scan_tap_fsm.sv
// Module: scan_tap_fsm
// The sixteen-state test-port controller, advanced on rising tck.
// Assumes rst_n is synchronous to tck and active low.
module scan_tap_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state function of the controller graph
    always_comb begin
        unique case (state)
            TLR:     nxt = tms ? TLR    : RTI;
            RTI:     nxt = tms ? SEL_DR : RTI;
            SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
            CAP_DR:  nxt = tms ? EX1_DR : SHF_DR;
            SHF_DR:  nxt = tms ? EX1_DR : SHF_DR;
            EX1_DR:  nxt = tms ? UPD_DR : PAU_DR;
            PAU_DR:  nxt = tms ? EX2_DR : PAU_DR;
            EX2_DR:  nxt = tms ? UPD_DR : SHF_DR;
            UPD_DR:  nxt = tms ? SEL_DR : RTI;
            SEL_IR:  nxt = tms ? TLR    : CAP_IR;
            CAP_IR:  nxt = tms ? EX1_IR : SHF_IR;
            SHF_IR:  nxt = tms ? EX1_IR : SHF_IR;
            EX1_IR:  nxt = tms ? UPD_IR : PAU_IR;
            PAU_IR:  nxt = tms ? EX2_IR : PAU_IR;
            EX2_IR:  nxt = tms ? UPD_IR : SHF_IR;
            UPD_IR:  nxt = tms ? SEL_DR : RTI;
            default: nxt = TLR;
        endcase
    end

    // State register with synchronous reset into Test-Logic-Reset
    always_ff @(posedge tck) begin
        if (!rst_n) state <= TLR;
        else        state <= nxt;
    end

endmodule

// File: rtl/scan_instr_reg.sv
// Module: scan_instr_reg
// Instruction shift stage (rising tck) and update stage (falling tck).
// Assumes the controller state comes from scan_tap_fsm on the same tck.
module scan_instr_reg
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tdi,
    input  tap_state_e state,
    output logic       ir_ser,
    output instr_e     ir
);

    logic [IR_W-1:0] sh_q;

    // Shift stage: capture the fixed pattern, then shift toward tdo
    always_ff @(posedge tck) begin
        if (!rst_n)               sh_q <= IR_CAPT;
        else if (state == CAP_IR) sh_q <= IR_CAPT;
        else if (state == SHF_IR) sh_q <= {tdi, sh_q[IR_W-1:1]};
    end

    // Update stage: latch on the falling edge; reset state selects bypass
    always_ff @(negedge tck) begin
        if (!rst_n)               ir <= I_BYPASS;
        else if (state == TLR)    ir <= I_BYPASS;
        else if (state == UPD_IR) ir <= instr_e'(sh_q);
    end

    assign ir_ser = sh_q[0];

endmodule

// File: rtl/scan_bound_reg.sv
// Module: scan_bound_reg
// Boundary register: N_IO pin cells plus one control cell at the tdi end.
// Each cell has a shift stage (rising tck) and an update stage (falling tck).
// Assumes the caller qualifies the strobes with the boundary instructions.
module scan_bound_reg #(
    parameter int N_IO = 8
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            cap_en,
    input  logic            shf_en,
    input  logic            upd_en,
    input  logic [N_IO-1:0] pin_in,
    output logic            ser_out,
    output logic [N_IO-1:0] upd_data,
    output logic            upd_ctl
);

    localparam int CHAIN = N_IO + 1;

    logic [CHAIN-1:0] sh_q;
    logic [CHAIN-1:0] cap_val;

    // Capture value: pins in cells 0..N_IO-1, control cell captures 0
    assign cap_val = {1'b0, pin_in};

    // Shift stage per cell: cell i takes its neighbour toward tdi
    for (genvar g = 0; g < CHAIN; g++) begin : g_cell
        logic nb;
        if (g == CHAIN - 1) begin : g_tdi_end
            assign nb = tdi;
        end else begin : g_mid
            assign nb = sh_q[g+1];
        end

        // One shift cell: capture or shift on rising tck
        always_ff @(posedge tck) begin
            if (!rst_n)      sh_q[g] <= 1'b0;
            else if (cap_en) sh_q[g] <= cap_val[g];
            else if (shf_en) sh_q[g] <= nb;
        end
    end

    // Update stage: parallel load on the falling edge in Update-DR
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            upd_data <= '0;
            upd_ctl  <= 1'b0;
        end else if (upd_en) begin
            upd_data <= sh_q[N_IO-1:0];
            upd_ctl  <= sh_q[CHAIN-1];
        end
    end

    assign ser_out = sh_q[0];

endmodule

// File: rtl/scan_port_ctrl.sv
// Module: scan_port_ctrl (top)
// Boundary-scan test port: controller, instruction decode, bypass and
// boundary registers, tdo source selection and user-chain handoff.
// Assumes one test clock domain; external streams are stable around falling tck.
module scan_port_ctrl
    import scan_pkg::*;
#(
    parameter int N_IO = 8
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_en,
    output logic            sel1,
    output logic            sel2,
    output logic            drck,
    output logic            idle,
    input  logic            user_tdo1,
    input  logic            user_tdo2,
    input  logic            rdbk_data,
    input  logic            cfg_dout,
    input  logic [N_IO-1:0] pin_in,
    input  logic [N_IO-1:0] core_out,
    input  logic            core_oe,
    output logic [N_IO-1:0] pad_out,
    output logic            pad_oe
);

    tap_state_e      st_q;
    instr_e          ir_q;
    logic            ir_ser;
    logic            bsr_ser;
    logic [N_IO-1:0] bsr_upd;
    logic            bsr_ctl;
    logic            bsr_sel;
    logic            byp_sel;
    logic            byp_q;
    logic            user_act;
    logic            gate_q;
    logic            src_d;
    logic            en_d;
    logic            tdo_q;
    logic            en_q;
    logic            extest;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (st_q)
    );

    scan_instr_reg u_ir (
        .tck    (tck),
        .rst_n  (rst_n),
        .tdi    (tdi),
        .state  (st_q),
        .ir_ser (ir_ser),
        .ir     (ir_q)
    );

    // Instruction decode
    assign bsr_sel  = (ir_q == I_EXTEST) || (ir_q == I_SAMPLE);
    assign byp_sel  = (ir_q == I_BYPASS) || (ir_q == I_RSVD);
    assign user_act = (ir_q == I_USER1) || (ir_q == I_USER2);
    assign extest   = (ir_q == I_EXTEST);
    assign sel1     = (ir_q == I_USER1);
    assign sel2     = (ir_q == I_USER2);
    assign idle     = (st_q == RTI);

    scan_bound_reg #(
        .N_IO (N_IO)
    ) u_bsr (
        .tck      (tck),
        .rst_n    (rst_n),
        .tdi      (tdi),
        .cap_en   (bsr_sel && (st_q == CAP_DR)),
        .shf_en   (bsr_sel && (st_q == SHF_DR)),
        .upd_en   (bsr_sel && (st_q == UPD_DR)),
        .pin_in   (pin_in),
        .ser_out  (bsr_ser),
        .upd_data (bsr_upd),
        .upd_ctl  (bsr_ctl)
    );

    // Bypass stage: capture 0, then one-bit delay of tdi
    always_ff @(posedge tck) begin
        if (!rst_n)                          byp_q <= 1'b0;
        else if (byp_sel && st_q == CAP_DR)  byp_q <= 1'b0;
        else if (byp_sel && st_q == SHF_DR)  byp_q <= tdi;
    end

    // Pad multiplexer: per-bit choice between boundary update and core
    for (genvar p = 0; p < N_IO; p++) begin : g_pad
        assign pad_out[p] = extest ? bsr_upd[p] : core_out[p];
    end
    assign pad_oe = extest ? bsr_ctl : core_oe;

    // Serial source selection by state and instruction
    always_comb begin
        src_d = 1'b0;
        if (st_q == SHF_IR) begin
            src_d = ir_ser;
        end else if (st_q == SHF_DR) begin
            unique case (ir_q)
                I_EXTEST, I_SAMPLE: src_d = bsr_ser;
                I_USER1:            src_d = user_tdo1;
                I_USER2:            src_d = user_tdo2;
                I_RDBK:             src_d = rdbk_data;
                I_CFG:              src_d = cfg_dout;
                I_BYPASS:           src_d = byp_q;
                default:            src_d = 1'b0;
            endcase
        end
    end

    // Output enable: shifting states only, never for the reserved code
    assign en_d = (st_q == SHF_IR) || ((st_q == SHF_DR) && (ir_q != I_RSVD));

    // Output stage launched on the falling edge
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            tdo_q <= en_d ? src_d : 1'b0;
            en_q  <= en_d;
        end
    end

    // Data-clock gate for user chains, set while tck is low
    always_ff @(negedge tck) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= user_act && ((st_q == CAP_DR) || (st_q == SHF_DR));
    end

    assign drck   = tck & gate_q;
    assign tdo    = tdo_q;
    assign tdo_en = en_q;

endmodule

// File: rtl/scan_port_ctrl_chk.sv
// Module: scan_port_ctrl_chk
// Temporal checks on the test port, bound into scan_port_ctrl.
// Assumes the bound signals are the controller state, instruction and update stage.
module scan_port_ctrl_chk
    import scan_pkg::*;
#(
    parameter int N_IO = 8
) (
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input tap_state_e      state,
    input instr_e          ir,
    input logic            tdo_en,
    input logic            sel1,
    input logic            sel2,
    input logic            drck,
    input logic            bsr_ctl,
    input logic [N_IO-1:0] bsr_upd
);

    logic [2:0] hi_cnt;

    // Count consecutive high tms samples, saturating at five
    always_ff @(posedge tck) begin
        if (!rst_n)            hi_cnt <= 3'd0;
        else if (!tms)         hi_cnt <= 3'd0;
        else if (hi_cnt != 5)  hi_cnt <= hi_cnt + 3'd1;
    end

    AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_cnt == 3'd5) |-> (state == TLR)); // R1

    AST_IR_BYPASS_IN_TLR: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TLR) |-> (ir == I_BYPASS)); // R2

    AST_UPD_HOLD: assert property (@(negedge tck) disable iff (!rst_n)
        (state != UPD_DR) |=> $stable({bsr_ctl, bsr_upd})); // R5

    AST_SEL_EXCLUSIVE: assert property (@(posedge tck) disable iff (!rst_n)
        !(sel1 && sel2)); // R7

    AST_DRCK_USER_ONLY: assert property (@(negedge tck) disable iff (!rst_n)
        drck |-> (sel1 || sel2)); // R8

    AST_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> ((state == SHF_IR) || (state == SHF_DR))); // R10

    AST_OE_NOT_RESERVED: assert property (@(posedge tck) disable iff (!rst_n)
        (tdo_en && state == SHF_DR) |-> (ir != I_RSVD)); // R11

endmodule

bind scan_port_ctrl scan_port_ctrl_chk #(
    .N_IO (N_IO)
) u_chk (
    .tck     (tck),
    .rst_n   (rst_n),
    .tms     (tms),
    .state   (st_q),
    .ir      (ir_q),
    .tdo_en  (tdo_en),
    .sel1    (sel1),
    .sel2    (sel2),
    .drck    (drck),
    .bsr_ctl (bsr_ctl),
    .bsr_upd (bsr_upd)
);

// File: tb/scan_port_ctrl_bench.sv
// Scoreboard bench: scan tasks queue expected tdo bits, a monitor compares.
module scan_port_ctrl_bench;

    localparam int N = 8;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic         tdo, tdo_en, sel1, sel2, drck, idle;
    logic         user_tdo1 = 1'b0;
    logic         user_tdo2 = 1'b0;
    logic         rdbk_data = 1'b0;
    logic         cfg_dout = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] core_out = 8'h0F;
    logic         core_oe = 1'b0;
    logic [N-1:0] pad_out;
    logic         pad_oe;

    int total = 0;
    int bad = 0;
    int drck_cnt = 0;
    bit done = 0;

    typedef struct {
        logic  v;
        string tag;
    } item_t;
    item_t exp_q[$];
    logic  act_q[$];

    always #5 tck = ~tck;

    scan_port_ctrl #(.N_IO(N)) u_scan_port_ctrl (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_en(tdo_en), .sel1(sel1), .sel2(sel2),
        .drck(drck), .idle(idle),
        .user_tdo1(user_tdo1), .user_tdo2(user_tdo2),
        .rdbk_data(rdbk_data), .cfg_dout(cfg_dout),
        .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always @(posedge drck) drck_cnt++;

    // Monitor: pop observed tdo bits and compare with queued expectations
    always @(posedge tck) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t e;
            logic  a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            total++;
            if (a !== e.v) begin
                bad++;
                $display("FAIL %s tdo: actual=%b expected=%b", e.tag, a, e.v);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One tck period: sample outputs after falling edge, then drive inputs
    task automatic step(input logic t_ms, input logic t_di, output logic o_tdo, output logic o_en);
        @(negedge tck);
        #2;
        o_tdo = tdo;
        o_en  = tdo_en;
        tms   = t_ms;
        tdi   = t_di;
    endtask

    task automatic go(input logic t_ms);
        logic d0, d1;
        step(t_ms, 1'b0, d0, d1);
    endtask

    // Instruction scan from Run-Test/Idle back to Run-Test/Idle
    task automatic shift_ir(input logic [2:0] code);
        logic o, e;
        go(1); go(1); go(0); go(0);
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back('{v: (i == 0), tag: "R2"});
            step(i == 2, code[i], o, e);
            act_q.push_back(o);
            chk("R10 tdo_en in Shift-IR", 32'(e), 32'd1);
        end
        go(1); go(0);
    endtask

    // Data scan of len bits from Run-Test/Idle back to Run-Test/Idle
    task automatic shift_dr(input int len, input logic [31:0] din, input logic [31:0] exp,
                            input logic en_exp, input string tag);
        logic o, e;
        go(1); go(0); go(0);
        for (int i = 0; i < len; i++) begin
            exp_q.push_back('{v: (en_exp ? exp[i] : 1'b0), tag: tag});
            step(i == len - 1, din[i], o, e);
            act_q.push_back(o);
            chk({tag, " tdo_en in Shift-DR"}, 32'(e), 32'(en_exp));
        end
        go(1); go(0);
    endtask

    initial begin
        repeat (4) go(1);
        rst_n = 1'b1;
        go(1);
        // Reset state: Test-Logic-Reset, bypass instruction, port disabled
        @(negedge tck); #2;
        chk("R1 idle low in reset state", 32'(idle), 32'd0);
        chk("R10 tdo_en low after reset", 32'(tdo_en), 32'd0);
        chk("R7 selects low after reset", {30'd0, sel1, sel2}, 32'd0);
        chk("R6 pads follow core after reset", {23'd0, pad_oe, pad_out}, {23'd0, 1'b0, 8'h0F});
        go(0);
        @(negedge tck); #2;
        chk("R9 idle high in Run-Test/Idle", 32'(idle), 32'd1);

        // Bypass after reset: 0 then tdi delayed one bit
        drck_cnt = 0;
        shift_dr(4, 32'b1101, 32'b1010, 1'b1, "R4");
        chk("R8 no drck under bypass", drck_cnt, 0);

        // Sample/preload: capture pins, preload update stage
        pin_in = 8'hA5;
        shift_ir(3'b001);
        shift_dr(N + 1, 32'h13C, 32'h0A5, 1'b1, "R5");
        chk("R6 sample leaves pads to core", {23'd0, pad_oe, pad_out}, {23'd0, 1'b0, 8'h0F});

        // External test: preloaded value drives pads
        shift_ir(3'b000);
        chk("R6 extest drives preloaded pads", {23'd0, pad_oe, pad_out}, {23'd0, 1'b1, 8'h3C});
        pin_in = 8'h5A;
        shift_dr(N + 1, 32'h05F, 32'h05A, 1'b1, "R3");
        chk("R5 extest update stage", {23'd0, pad_oe, pad_out}, {23'd0, 1'b0, 8'h5F});

        // User chain 1
        user_tdo1 = 1'b1; user_tdo2 = 1'b0;
        shift_ir(3'b010);
        chk("R7 sel1 under user 1", {30'd0, sel1, sel2}, 32'd2);
        chk("R6 pads back to core", {23'd0, pad_oe, pad_out}, {23'd0, 1'b0, 8'h0F});
        drck_cnt = 0;
        shift_dr(5, 32'h0, 32'h1F, 1'b1, "R3 user1");
        chk("R8 drck pulses user 1", drck_cnt, 6);

        // User chain 2
        user_tdo1 = 1'b0; user_tdo2 = 1'b1;
        shift_ir(3'b011);
        chk("R7 sel2 under user 2", {30'd0, sel1, sel2}, 32'd1);
        drck_cnt = 0;
        shift_dr(3, 32'h0, 32'h7, 1'b1, "R3 user2");
        chk("R8 drck pulses user 2", drck_cnt, 4);

        // Readback and configure streams
        user_tdo2 = 1'b0; rdbk_data = 1'b1; cfg_dout = 1'b0;
        shift_ir(3'b100);
        chk("R7 selects low under readback", {30'd0, sel1, sel2}, 32'd0);
        shift_dr(3, 32'h0, 32'h7, 1'b1, "R3 readback");
        rdbk_data = 1'b0; cfg_dout = 1'b1;
        shift_ir(3'b101);
        shift_dr(3, 32'h0, 32'h7, 1'b1, "R3 configure");
        cfg_dout = 1'b0;

        // Reserved code keeps the port disabled
        shift_ir(3'b110);
        shift_dr(3, 32'h7, 32'h0, 1'b0, "R11");

        // Five high tms edges from Shift-DR under user 1 reach reset state
        shift_ir(3'b010);
        go(1); go(0); go(0);
        repeat (5) go(1);
        @(negedge tck); #2;
        chk("R1 idle low after five tms highs", 32'(idle), 32'd0);
        chk("R2 instruction back to bypass", {30'd0, sel1, sel2}, 32'd0);
        go(0);
        shift_dr(2, 32'b01, 32'b10, 1'b1, "R2 bypass after reset");

        repeat (4) @(posedge tck);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge tck);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule